// File: doc/BRIEF.md
# Address Translation Cache with Targeted Invalidation

This block holds a small, fully associative set of recently used virtual-to-physical page translations. Each slot keeps a virtual page tag, the physical frame number, and the page's permission bits. A lookup takes a virtual address. On a hit, the physical address and permissions come back one cycle later, and no page-table walk takes place. On a miss, the block asks an external walker for the missing translation. It then waits for the walker's fill, forwards the fill to the requester, and stores it unless the walker reported a fault.

The stored translations are not kept coherent with the page tables in hardware. A slot keeps returning what it was filled with until software removes it. Software does this either by invalidating one virtual page number (a shootdown) or by flushing every slot at once. The low page-offset bits never enter the cache and are copied straight into the physical address.

The lookup request, the lookup response and the walk request are valid/ready channels. A request is accepted only when `req_ready` is high. `req_ready` stays low from acceptance until the response has been taken. A response, once valid, holds all its fields steady until `rsp_ready` is seen high. A walk request holds `walk_vpn` steady until `walk_ready` is seen high. The fill, invalidate and flush inputs are single-cycle strobes with no back-pressure.

Top module: `xlat_cache`

## Requirements
- R1: After reset no slot is valid. `req_ready` is 1, and `rsp_valid` and `walk_valid` are 0. The first lookup of any address misses.
- R2: A lookup that matches a valid slot gives `rsp_valid`=1 and `rsp_hit`=1 in the cycle after acceptance. It returns that slot's frame number and permissions, with `rsp_fault`=0, and raises no walk request.
- R3: A lookup that misses raises `walk_valid` in the cycle after acceptance, with `walk_vpn` equal to the address's page number. After the walk handshake, a `fill_valid` pulse produces a response in the following cycle. That response carries the fill's frame number, permissions and fault flag, with `rsp_hit`=0.
- R4: `rsp_paddr` is the frame number concatenated above the 12 offset bits of the accepted virtual address, which pass through unchanged.
- R5: A stored slot returns the permissions it was filled with, even when the walker would now report different ones, until it is invalidated or flushed. Permission encoding is bit 3 user-accessible, bit 2 readable, bit 1 writable, bit 0 executable.
- R6: An `inv_valid` pulse clears every slot whose tag equals `inv_vpn`. Later lookups of that page miss, and other pages still hit. An invalidate of the requested page in the same cycle as acceptance also makes that lookup miss.
- R7: A `flush` pulse clears every slot in one cycle, so all later lookups miss until they are refilled.
- R8: If an invalidate names the pending page in the same cycle as its fill, the response is still delivered with the fill data, but the fill is not stored.
- R9: A fill with `fill_fault`=1 yields a response with `rsp_fault`=1 and is never stored.
- R10: A fill goes to the lowest-numbered invalid slot. When all slots are valid, it goes to the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one after each such replacement.
- R11: `req_ready` is 0 from acceptance until the response handshake. An unaccepted response keeps `rsp_valid` and all its fields stable. An unaccepted walk request keeps `walk_valid` and `walk_vpn` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | PFN_W+OFF_W | Translated physical address |
| rsp_perm | output | 4 | Permissions {user, read, write, exec} |
| rsp_hit | output | 1 | 1 if served from a stored slot |
| rsp_fault | output | 1 | Walker reported a fault |
| walk_valid | output | 1 | Walk request valid |
| walk_ready | input | 1 | Walker accepts the request |
| walk_vpn | output | VPN_W | Page number to walk |
| fill_valid | input | 1 | Walker result strobe |
| fill_pfn | input | PFN_W | Walker frame number |
| fill_perm | input | 4 | Walker permissions |
| fill_fault | input | 1 | Walker reports a fault |
| inv_valid | input | 1 | Invalidate-one-page strobe |
| inv_vpn | input | VPN_W | Page number to invalidate |
| flush | input | 1 | Clear all slots |

## Verification
A hit response is due exactly one cycle after the accepting edge. A miss shows `walk_valid` in that same cycle, and its response comes one cycle after the edge that takes the fill. Every slot change from an invalidate, flush or fill is visible to a lookup accepted on the next edge. The bench drives each strobe half a cycle before the edge that should take it and samples half a cycle after. It checks the response at exactly the due cycle and not in a window. When a test holds back `rsp_ready` or `walk_ready`, the bench checks the held values on every stalled cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef struct packed {
    logic user;
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } fsm_t;

endpackage

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid,
  input  logic [IDX_W-1:0] rr_ptr,
  output logic [IDX_W-1:0] idx,
  output logic             full
);
  // lowest free slot first, otherwise the round-robin slot
  always_comb begin
    full = &valid;
    idx  = rr_ptr;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output perm_t            lk_perm,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PFN_W-1:0] wr_pfn,
  input  perm_t            wr_perm,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             flush
);
  localparam int IDX_W = $clog2(N);

  logic [N-1:0]     valid_q;
  logic [VPN_W-1:0] tag_q  [N];
  logic [PFN_W-1:0] pfn_q  [N];
  perm_t            perm_q [N];
  logic [IDX_W-1:0] rr_q;
  logic [N-1:0]     match;
  logic [N-1:0]     kill;
  logic [IDX_W-1:0] vic_idx;
  logic             vic_full;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign kill[g]  = flush | (inv_en & (tag_q[g] == inv_vpn));
      assign match[g] = valid_q[g] & (tag_q[g] == lk_vpn) & ~kill[g];
    end
  endgenerate

  always_comb begin
    lk_hit  = |match;
    lk_pfn  = '0;
    lk_perm = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        lk_pfn  = lk_pfn | pfn_q[i];
        lk_perm = lk_perm | perm_q[i];
      end
    end
  end

  xlat_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
    .valid  (valid_q),
    .rr_ptr (rr_q),
    .idx    (vic_idx),
    .full   (vic_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_q & ~kill;
      if (wr_en) begin
        valid_q[vic_idx] <= 1'b1;
        if (vic_full) rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[vic_idx]  <= wr_vpn;
      pfn_q[vic_idx]  <= wr_pfn;
      perm_q[vic_idx] <= wr_perm;
    end
  end
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int OFF_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VPN_W+OFF_W-1:0] req_vaddr,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  output perm_t                  rsp_perm,
  output logic                   rsp_hit,
  output logic                   rsp_fault,
  output logic                   walk_valid,
  input  logic                   walk_ready,
  output logic [VPN_W-1:0]       walk_vpn,
  input  logic                   fill_valid,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  perm_t                  fill_perm,
  input  logic                   fill_fault,
  input  logic                   inv_valid,
  input  logic [VPN_W-1:0]       inv_vpn,
  input  logic                   flush,
  input  logic                   lk_hit,
  input  logic [PFN_W-1:0]       lk_pfn,
  input  perm_t                  lk_perm,
  output logic                   wr_en
);
  fsm_t             st_q;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic             take_req;
  logic             take_fill;

  assign req_ready  = (st_q == ST_IDLE);
  assign rsp_valid  = (st_q == ST_RESP);
  assign walk_valid = (st_q == ST_WALK);
  assign walk_vpn   = vpn_q;
  assign take_req   = req_valid & req_ready;
  assign take_fill  = (st_q == ST_WAIT) & fill_valid;
  // a same-cycle shootdown or flush beats the fill
  assign wr_en      = take_fill & ~fill_fault & ~flush
                      & ~(inv_valid & (inv_vpn == vpn_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      vpn_q     <= '0;
      off_q     <= '0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (take_req) begin
          vpn_q <= req_vaddr[VPN_W+OFF_W-1:OFF_W];
          off_q <= req_vaddr[OFF_W-1:0];
          if (lk_hit) begin
            rsp_paddr <= {lk_pfn, req_vaddr[OFF_W-1:0]};
            rsp_perm  <= lk_perm;
            rsp_hit   <= 1'b1;
            rsp_fault <= 1'b0;
            st_q      <= ST_RESP;
          end else begin
            st_q <= ST_WALK;
          end
        end
        ST_WALK: if (walk_ready) st_q <= ST_WAIT;
        ST_WAIT: if (take_fill) begin
          rsp_paddr <= {fill_pfn, off_q};
          rsp_perm  <= fill_perm;
          rsp_hit   <= 1'b0;
          rsp_fault <= fill_fault;
          st_q      <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [3:0]       rsp_perm,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic             walk_valid,
  input  logic             walk_ready,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             fill_valid,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [3:0]       fill_perm,
  input  logic             fill_fault,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             flush
);
  logic             lk_hit;
  logic [PFN_W-1:0] lk_pfn;
  perm_t            lk_perm;
  logic             wr_en;
  perm_t            rsp_perm_s;
  perm_t            fill_perm_s;

  assign fill_perm_s = perm_t'(fill_perm);
  assign rsp_perm    = rsp_perm_s;

  xlat_store #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_vpn  (req_vaddr[VA_W-1:OFF_W]),
    .lk_hit  (lk_hit),
    .lk_pfn  (lk_pfn),
    .lk_perm (lk_perm),
    .wr_en   (wr_en),
    .wr_vpn  (walk_vpn),
    .wr_pfn  (fill_pfn),
    .wr_perm (fill_perm_s),
    .inv_en  (inv_valid),
    .inv_vpn (inv_vpn),
    .flush   (flush)
  );

  xlat_ctrl #(.VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_paddr  (rsp_paddr),
    .rsp_perm   (rsp_perm_s),
    .rsp_hit    (rsp_hit),
    .rsp_fault  (rsp_fault),
    .walk_valid (walk_valid),
    .walk_ready (walk_ready),
    .walk_vpn   (walk_vpn),
    .fill_valid (fill_valid),
    .fill_pfn   (fill_pfn),
    .fill_perm  (fill_perm_s),
    .fill_fault (fill_fault),
    .inv_valid  (inv_valid),
    .inv_vpn    (inv_vpn),
    .flush      (flush),
    .lk_hit     (lk_hit),
    .lk_pfn     (lk_pfn),
    .lk_perm    (lk_perm),
    .wr_en      (wr_en)
  );
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int OFF_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [VPN_W+OFF_W-1:0] req_vaddr,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [PFN_W+OFF_W-1:0] rsp_paddr,
  input logic [3:0]             rsp_perm,
  input logic                   rsp_hit,
  input logic                   rsp_fault,
  input logic                   walk_valid,
  input logic                   walk_ready,
  input logic [VPN_W-1:0]       walk_vpn
);
  logic [OFF_W-1:0] seen_off;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_off <= '0;
    else if (req_valid && req_ready) seen_off <= req_vaddr[OFF_W-1:0];
  end

  assert_hit_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && rsp_hit) |-> $past(req_valid && req_ready));

  assert_miss_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(walk_valid) |-> $past(req_valid && req_ready));

  assert_offset_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_paddr[OFF_W-1:0] == seen_off));

  assert_fault_not_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> !rsp_hit);

  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_perm)
                                   && $stable(rsp_hit) && $stable(rsp_fault)));

  assert_walk_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_valid && !walk_ready) |=> (walk_valid && $stable(walk_vpn)));
endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_vaddr  (req_vaddr),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_paddr  (rsp_paddr),
  .rsp_perm   (rsp_perm),
  .rsp_hit    (rsp_hit),
  .rsp_fault  (rsp_fault),
  .walk_valid (walk_valid),
  .walk_ready (walk_ready),
  .walk_vpn   (walk_vpn)
);

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic [3:0]  rsp_perm;
  logic        rsp_hit;
  logic        rsp_fault;
  logic        walk_valid;
  logic        walk_ready = 1'b1;
  logic [19:0] walk_vpn;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_pfn = '0;
  logic [3:0]  fill_perm = '0;
  logic        fill_fault = 1'b0;
  logic        inv_valid = 1'b0;
  logic [19:0] inv_vpn = '0;
  logic        flush = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  xlat_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_perm(rsp_perm), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .walk_valid(walk_valid), .walk_ready(walk_ready), .walk_vpn(walk_vpn),
    .fill_valid(fill_valid), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .fill_fault(fill_fault), .inv_valid(inv_valid), .inv_vpn(inv_vpn),
    .flush(flush)
  );

  typedef struct packed {
    logic [31:0] va;
    logic        hit;
    logic [19:0] pfn;
    logic [3:0]  perm;
  } vec_t;

  // pfn/perm: walker data on a miss, expected cached data on a hit
  localparam vec_t VEC [8] = '{
    '{32'h12345ABC, 1'b0, 20'h00A11, 4'b1110},
    '{32'h12345010, 1'b1, 20'h00A11, 4'b1110},
    '{32'h0F00DFFF, 1'b0, 20'h7BEEF, 4'b1101},
    '{32'h12345000, 1'b1, 20'h00A11, 4'b1110},
    '{32'h0F00D001, 1'b1, 20'h7BEEF, 4'b1101},
    '{32'hFFFFF800, 1'b0, 20'h00001, 4'b0100},
    '{32'hFFFFF7FF, 1'b1, 20'h00001, 4'b0100},
    '{32'h00000000, 1'b0, 20'hFFFFF, 4'b1111}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one lookup; walker answers with fpfn/fperm/ffault when asked
  task automatic run_lkp(input logic [31:0] va, input logic [19:0] fpfn,
                         input logic [3:0] fperm, input bit ffault,
                         input bit inv_req, input bit inv_fill,
                         input int wdly, input int rdly,
                         input bit e_hit, input logic [19:0] e_pfn,
                         input logic [3:0] e_perm, input bit e_flt,
                         input string tag);
    logic [31:0] pa;
    req_valid = 1'b1;
    req_vaddr = va;
    if (inv_req) begin inv_valid = 1'b1; inv_vpn = va[31:12]; end
    if (wdly > 0) walk_ready = 1'b0;
    if (rdly > 0) rsp_ready = 1'b0;
    step();
    req_valid = 1'b0;
    inv_valid = 1'b0;
    if (rsp_valid) begin
      chk({tag, " R2 no walk on hit"}, walk_valid, 0);
    end else begin
      chk({tag, " R3 walk raised"}, walk_valid, 1);
      chk({tag, " R3 walk vpn"}, walk_vpn, va[31:12]);
      for (int k = 0; k < wdly; k++) begin
        step();
        chk({tag, " R11 walk held"}, {walk_valid, walk_vpn}, {1'b1, va[31:12]});
      end
      walk_ready = 1'b1;
      step();
      fill_valid = 1'b1;
      fill_pfn   = fpfn;
      fill_perm  = fperm;
      fill_fault = ffault;
      if (inv_fill) begin inv_valid = 1'b1; inv_vpn = va[31:12]; end
      step();
      fill_valid = 1'b0;
      fill_fault = 1'b0;
      inv_valid  = 1'b0;
      chk({tag, " R3 rsp after fill"}, rsp_valid, 1);
    end
    chk({tag, " R2/R3 hit flag"}, rsp_hit, e_hit);
    chk({tag, " R4 paddr"}, rsp_paddr, {e_pfn, va[11:0]});
    chk({tag, " R5 perm"}, rsp_perm, e_perm);
    chk({tag, " R9 fault"}, rsp_fault, e_flt);
    pa = rsp_paddr;
    for (int k = 0; k < rdly; k++) begin
      step();
      chk({tag, " R11 rsp held"}, {rsp_valid, req_ready, rsp_paddr}, {1'b1, 1'b0, pa});
    end
    rsp_ready = 1'b1;
    step();
    chk({tag, " R11 rsp taken"}, {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic miss(input logic [31:0] va, input logic [19:0] p, input string tag);
    run_lkp(va, p, 4'b0110, 0, 0, 0, 0, 0, 1'b0, p, 4'b0110, 1'b0, tag);
  endtask

  task automatic hit(input logic [31:0] va, input logic [19:0] p, input string tag);
    run_lkp(va, 20'hDEAD0, 4'b0000, 0, 0, 0, 0, 0, 1'b1, p, 4'b0110, 1'b0, tag);
  endtask

  task automatic pulse_inv(input logic [19:0] v);
    inv_valid = 1'b1;
    inv_vpn   = v;
    step();
    inv_valid = 1'b0;
  endtask

  task automatic pulse_flush();
    flush = 1'b1;
    step();
    flush = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {req_ready, rsp_valid, walk_valid}, 3'b100);

    // vector table: R1 empty start, R2 hits, R3 misses, R4 offset
    for (int k = 0; k < 8; k++)
      run_lkp(VEC[k].va, VEC[k].pfn, VEC[k].perm, 0, 0, 0, 0, 0,
              VEC[k].hit, VEC[k].pfn, VEC[k].perm, 1'b0, "vector");

    // R5: walker now reports no permissions, cached slot still wins
    run_lkp(32'h12345444, 20'h00A11, 4'b0000, 0, 0, 0, 0, 0,
            1'b1, 20'h00A11, 4'b1110, 1'b0, "R5 stale");

    // R6: shootdown of one page
    pulse_inv(20'h12345);
    run_lkp(32'h12345444, 20'h00B22, 4'b0100, 0, 0, 0, 0, 0,
            1'b0, 20'h00B22, 4'b0100, 1'b0, "R6 after inv");
    run_lkp(32'h0F00D123, 20'h0, 4'b0, 0, 0, 0, 0, 0,
            1'b1, 20'h7BEEF, 4'b1101, 1'b0, "R6 other kept");
    // R6: invalidate in the accept cycle forces a miss
    run_lkp(32'h0F00D123, 20'h7BEEF, 4'b1101, 0, 1, 0, 0, 0,
            1'b0, 20'h7BEEF, 4'b1101, 1'b0, "R6 inv at accept");
    run_lkp(32'h0F00D124, 20'h0, 4'b0, 0, 0, 0, 0, 0,
            1'b1, 20'h7BEEF, 4'b1101, 1'b0, "R6 refilled");

    // R8: invalidate collides with fill
    run_lkp(32'h55555321, 20'h0C0DE, 4'b1100, 0, 0, 1, 0, 0,
            1'b0, 20'h0C0DE, 4'b1100, 1'b0, "R8 collide");
    miss(32'h55555321, 20'h0C0DF, "R8 not stored");

    // R9: faulting fill
    run_lkp(32'h66666abc, 20'h0, 4'b0000, 1, 0, 0, 0, 0,
            1'b0, 20'h0, 4'b0000, 1'b1, "R9 fault");
    miss(32'h66666abc, 20'h01234, "R9 not stored");
    hit(32'h66666abd, 20'h01234, "R9 later fill cached");

    // R7: flush all
    pulse_flush();
    miss(32'h0F00D000, 20'h00333, "R7 flushed a");
    miss(32'h66666000, 20'h00444, "R7 flushed b");
    hit(32'h0F00D001, 20'h00333, "R7 refill");
    pulse_flush();

    // R10: fill slots 0..7, then round-robin from slot 0
    for (int k = 0; k < 8; k++) miss({20'h00100 + 20'(k), 12'h0}, 20'h10 + 20'(k), "R10 fill");
    miss(32'h00108000, 20'h18, "R10 evict slot0");
    hit(32'h00101000, 20'h11, "R10 slot1 kept");
    miss(32'h00100000, 20'h10, "R10 evict slot1");
    hit(32'h00102000, 20'h12, "R10 slot2 kept");
    miss(32'h00101000, 20'h11, "R10 evict slot2");
    pulse_inv(20'h00105);
    miss(32'h00109000, 20'h19, "R10 free slot first");
    hit(32'h00103000, 20'h13, "R10 ptr slot kept");
    miss(32'h0010A000, 20'h1A, "R10 evict slot3");
    miss(32'h00103000, 20'h13, "R10 slot3 gone");

    // R11: back-pressure on walk and response channels
    run_lkp(32'h77777fed, 20'h0ABCD, 4'b1010, 0, 0, 0, 2, 3,
            1'b0, 20'h0ABCD, 4'b1010, 1'b0, "R11 stall miss");
    run_lkp(32'h77777fee, 20'h0, 4'b0, 0, 0, 0, 0, 3,
            1'b1, 20'h0ABCD, 4'b1010, 1'b0, "R11 stall hit");

    finish_run();
  end
endmodule